// File: doc/BRIEF.md
# Coprocessor Run Control and Host Interrupt

This block decides when a coprocessor core runs, tells the host CPU when the core has stopped, and selects which side owns the external ROM and work RAM buses. The host sees it as a small byte-wide register window. A write to the upper byte of the program counter launches the core. The core, or the host, can end a run. When the core ends a run with its STOP instruction, a sticky interrupt flag is set. The host clears that flag by reading it.

The block also holds the configuration bits that surround a run. These are the interrupt mask, the high-speed multiply select, the core clock-rate select, and the two bus-ownership bits. The block drives a run enable toward the core, a one-cycle load strobe together with the start address, a level interrupt line toward the host, and the two bus grants. The asynchronous active-low reset is released synchronously inside the block, two clock cycles after the reset pin rises.

Top module: `rc_top`

## Requirements
- R1: After reset, run_en, host_irq, pc_load, both grants, fast_mult and clk_fast are 0, and every register read returns 0x00 except bit 6 of offset 0x30, which follows rom_busy.
- R2: A host write to offset 0x1F (upper program-counter byte) makes run_en 1 from the next cycle. In that cycle pc_load is 1 and pc_value equals {byte at 0x1F, byte at 0x1E}. Bit 5 of offset 0x30 reads 1 while running. A write to offset 0x1E alone starts nothing.
- R3: While running, a core_stop pulse clears run_en on the next cycle and sets the interrupt flag, which reads as bit 7 of offset 0x31.
- R4: A host write to offset 0x30 with bit 5 at 0 ends a run without setting the interrupt flag. A write there with bit 5 at 1 has no effect.
- R5: host_irq equals the interrupt flag AND NOT bit 7 of the config register at offset 0x37.
- R6: A host read of offset 0x31 clears the interrupt flag from the next cycle. If a stop is accepted in the same cycle, the flag is set instead.
- R7: A write to offset 0x1F while running keeps run_en at 1 and pulses pc_load. It never sets the interrupt flag, and a core_stop in that same cycle is ignored.
- R8: core_stop while idle has no effect on run_en or the interrupt flag.
- R9: Bit 6 of offset 0x30 mirrors the rom_busy input.
- R10: In the screen-mode register at offset 0x3A, bit 4 drives rom_to_core and bit 3 drives ram_to_core (1 = coprocessor, 0 = host).
- R11: clk_fast equals bit 0 of offset 0x39. fast_mult equals bit 5 of offset 0x37, forced to 0 while clk_fast is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr | input | 1 | Host register write strobe |
| hrd | input | 1 | Host register read strobe |
| haddr | input | ADDR_W | Host register offset |
| hwdata | input | DATA_W | Host write data |
| hrdata | output | DATA_W | Host read data, combinational; 0 when hrd is low |
| core_stop | input | 1 | Core executed STOP (one-cycle pulse) |
| rom_busy | input | 1 | Core ROM read through the data pointer in progress |
| run_en | output | 1 | Core run enable (the GO state) |
| pc_load | output | 1 | One-cycle strobe: core fetches from pc_value |
| pc_value | output | 2*DATA_W | Start address written by the host |
| host_irq | output | 1 | Level interrupt to the host |
| rom_to_core | output | 1 | External ROM owned by the coprocessor |
| ram_to_core | output | 1 | Work RAM owned by the coprocessor |
| fast_mult | output | 1 | Effective high-speed multiply select |
| clk_fast | output | 1 | Double core clock rate select |

## Verification
The directed sequences check the following cases:
- a start followed by a core stop, with the interrupt both unmasked and masked;
- a host stop through the GO bit, which separates a host-ended run from a core-ended one because only the core stop sets the flag;
- restart while running, with and without a simultaneous stop, to confirm that a restart never raises the interrupt;
- a status read in the same cycle as a stop, to confirm that the set wins over the clear.

Random cycles then mix writes to every offset, stray writes, reads, stop pulses and ROM-busy levels. A per-cycle model of run state, flag, mask and bus bits catches ordering errors that a single directed test would miss.

// File: rtl/rc_pkg.sv
`timescale 1ns/1ps
package rc_pkg;
  // Register offsets (host view)
  localparam logic [7:0] OFS_PC_LO   = 8'h1E;
  localparam logic [7:0] OFS_PC_HI   = 8'h1F;
  localparam logic [7:0] OFS_STAT_LO = 8'h30;
  localparam logic [7:0] OFS_STAT_HI = 8'h31;
  localparam logic [7:0] OFS_CFG     = 8'h37;
  localparam logic [7:0] OFS_CLK     = 8'h39;
  localparam logic [7:0] OFS_SCM     = 8'h3A;

  // Bit positions
  localparam int STAT_GO_BIT    = 5;
  localparam int STAT_ROMRD_BIT = 6;
  localparam int STAT_IRQ_BIT   = 7;  // in the upper status byte
  localparam int CFG_MASK_BIT   = 7;
  localparam int CFG_FMUL_BIT   = 5;
  localparam int CLK_FAST_BIT   = 0;
  localparam int SCM_ROM_BIT    = 4;
  localparam int SCM_RAM_BIT    = 3;

  typedef enum logic {RS_IDLE = 1'b0, RS_RUN = 1'b1} run_state_t;
endpackage

// File: rtl/rc_rst_sync.sv
`timescale 1ns/1ps
module rc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/rc_cfg_regs.sv
`timescale 1ns/1ps
module rc_cfg_regs
  import rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pc_start,
  output logic              go_clear,
  output logic [PC_W-1:0]   pc_value,
  output logic              irq_mask,
  output logic              fast_mult,
  output logic              clk_fast,
  output logic              rom_to_core,
  output logic              ram_to_core
);
  logic [DATA_W-1:0] pc_lo_q, pc_lo_d, pc_hi_q, pc_hi_d;
  logic              mask_q, mask_d, fmul_q, fmul_d, cfast_q, cfast_d;
  logic              rom_q, rom_d, ram_q, ram_d;

  logic wr_pc_lo, wr_pc_hi, wr_stat, wr_cfg, wr_clk, wr_scm;

  always_comb begin
    wr_pc_lo = wr_en && (addr == ADDR_W'(OFS_PC_LO));
    wr_pc_hi = wr_en && (addr == ADDR_W'(OFS_PC_HI));
    wr_stat  = wr_en && (addr == ADDR_W'(OFS_STAT_LO));
    wr_cfg   = wr_en && (addr == ADDR_W'(OFS_CFG));
    wr_clk   = wr_en && (addr == ADDR_W'(OFS_CLK));
    wr_scm   = wr_en && (addr == ADDR_W'(OFS_SCM));
  end

  always_comb begin
    pc_lo_d = pc_lo_q;
    pc_hi_d = pc_hi_q;
    mask_d  = mask_q;
    fmul_d  = fmul_q;
    cfast_d = cfast_q;
    rom_d   = rom_q;
    ram_d   = ram_q;
    if (wr_pc_lo) pc_lo_d = wdata;
    if (wr_pc_hi) pc_hi_d = wdata;
    if (wr_cfg) begin
      mask_d = wdata[CFG_MASK_BIT];
      fmul_d = wdata[CFG_FMUL_BIT];
    end
    if (wr_clk) cfast_d = wdata[CLK_FAST_BIT];
    if (wr_scm) begin
      rom_d = wdata[SCM_ROM_BIT];
      ram_d = wdata[SCM_RAM_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_lo_q <= '0;
      pc_hi_q <= '0;
      mask_q  <= 1'b0;
      fmul_q  <= 1'b0;
      cfast_q <= 1'b0;
      rom_q   <= 1'b0;
      ram_q   <= 1'b0;
    end else begin
      pc_lo_q <= pc_lo_d;
      pc_hi_q <= pc_hi_d;
      mask_q  <= mask_d;
      fmul_q  <= fmul_d;
      cfast_q <= cfast_d;
      rom_q   <= rom_d;
      ram_q   <= ram_d;
    end
  end

  assign pc_start    = wr_pc_hi;
  assign go_clear    = wr_stat && !wdata[STAT_GO_BIT];
  assign pc_value    = {pc_hi_q, pc_lo_q};
  assign irq_mask    = mask_q;
  assign clk_fast    = cfast_q;
  assign fast_mult   = fmul_q && !cfast_q;
  assign rom_to_core = rom_q;
  assign ram_to_core = ram_q;

  // R11: the fast multiply select never stays on at the doubled clock rate
  assert_clk_mult_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_fast |-> !fast_mult);

  // R10: bus ownership only moves on a screen-mode write
  assert_grant_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_scm |=> ($stable(rom_to_core) && $stable(ram_to_core)));
endmodule

// File: rtl/rc_run_ctrl.sv
`timescale 1ns/1ps
module rc_run_ctrl
  import rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pc_start,
  input  logic go_clear,
  input  logic core_stop,
  output logic run_en,
  output logic pc_load,
  output logic stop_evt
);
  run_state_t state_q, state_d;
  logic       load_q;

  always_comb begin
    state_d  = state_q;
    stop_evt = 1'b0;
    if (pc_start) begin
      state_d = RS_RUN;                 // launch or restart, stop ignored
    end else if (state_q == RS_RUN) begin
      if (core_stop) begin
        state_d  = RS_IDLE;
        stop_evt = 1'b1;
      end else if (go_clear) begin
        state_d  = RS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= pc_start;
    end
  end

  assign run_en  = (state_q == RS_RUN);
  assign pc_load = load_q;

  // R2: a program-counter upper-byte write always leaves the core running
  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_start |=> (run_en && pc_load));

  // R3: a stop from the core while running ends the run
  assert_core_stop_halts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && core_stop && !pc_start) |=> !run_en);

  // R8: without a start, an idle core stays idle
  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !pc_start) |=> !run_en);
endmodule

// File: rtl/rc_irq.sv
`timescale 1ns/1ps
module rc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_read,
  input  logic irq_mask,
  output logic irq_flag,
  output logic host_irq
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_read) flag_d = 1'b0;
    if (set_evt)  flag_d = 1'b1;        // a new stop wins over the clearing read
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_flag = flag_q;
  assign host_irq = flag_q && !irq_mask;

  // R3 / R6: an accepted stop leaves the flag set
  assert_stop_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> irq_flag);

  // R6: a status read without a stop leaves the flag clear
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_read && !set_evt) |=> !irq_flag);

  // R5: the flag only rises through an accepted stop
  assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flag) |-> $past(set_evt));
endmodule

// File: rtl/rc_top.sv
`timescale 1ns/1ps
module rc_top
  import rc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int PC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hwr,
  input  logic              hrd,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hwdata,
  output logic [DATA_W-1:0] hrdata,
  input  logic              core_stop,
  input  logic              rom_busy,
  output logic              run_en,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_value,
  output logic              host_irq,
  output logic              rom_to_core,
  output logic              ram_to_core,
  output logic              fast_mult,
  output logic              clk_fast
);
  logic rst_s_n;
  logic pc_start, go_clear, irq_mask, stop_evt, irq_flag, stat_hi_rd;
  logic [DATA_W-1:0] rd_mux;

  rc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  rc_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_s_n), .wr_en(hwr), .addr(haddr), .wdata(hwdata),
    .pc_start(pc_start), .go_clear(go_clear), .pc_value(pc_value),
    .irq_mask(irq_mask), .fast_mult(fast_mult), .clk_fast(clk_fast),
    .rom_to_core(rom_to_core), .ram_to_core(ram_to_core)
  );

  rc_run_ctrl u_run (
    .clk(clk), .rst_n(rst_s_n), .pc_start(pc_start), .go_clear(go_clear),
    .core_stop(core_stop), .run_en(run_en), .pc_load(pc_load),
    .stop_evt(stop_evt)
  );

  assign stat_hi_rd = hrd && (haddr == ADDR_W'(OFS_STAT_HI));

  rc_irq u_irq (
    .clk(clk), .rst_n(rst_s_n), .set_evt(stop_evt), .clr_read(stat_hi_rd),
    .irq_mask(irq_mask), .irq_flag(irq_flag), .host_irq(host_irq)
  );

  always_comb begin
    rd_mux = '0;
    if (haddr == ADDR_W'(OFS_PC_LO))        rd_mux = pc_value[DATA_W-1:0];
    else if (haddr == ADDR_W'(OFS_PC_HI))   rd_mux = pc_value[PC_W-1:DATA_W];
    else if (haddr == ADDR_W'(OFS_STAT_LO)) begin
      rd_mux[STAT_GO_BIT]    = run_en;
      rd_mux[STAT_ROMRD_BIT] = rom_busy;
    end else if (haddr == ADDR_W'(OFS_STAT_HI)) begin
      rd_mux[STAT_IRQ_BIT]   = irq_flag;
    end
  end

  assign hrdata = hrd ? rd_mux : '0;

  // R7: a restart while running never raises the interrupt flag
  assert_restart_quiet_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (pc_start && run_en && !irq_flag) |=> !irq_flag);

  // R4: a host stop through the GO bit does not raise the flag
  assert_host_stop_quiet_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (go_clear && !core_stop && !irq_flag) |=> !irq_flag);
endmodule

// File: tb/sim_rc_top.sv
`timescale 1ns/1ps
module sim_rc_top;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam realtime HALF = 5.0;   // 100 MHz

  logic clk, rst_n, hwr, hrd, core_stop, rom_busy;
  logic [AW-1:0] haddr;
  logic [DW-1:0] hwdata, hrdata;
  logic run_en, pc_load, host_irq, rom_to_core, ram_to_core, fast_mult, clk_fast;
  logic [2*DW-1:0] pc_value;

  rc_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .hwr(hwr), .hrd(hrd), .haddr(haddr),
    .hwdata(hwdata), .hrdata(hrdata), .core_stop(core_stop),
    .rom_busy(rom_busy), .run_en(run_en), .pc_load(pc_load),
    .pc_value(pc_value), .host_irq(host_irq), .rom_to_core(rom_to_core),
    .ram_to_core(ram_to_core), .fast_mult(fast_mult), .clk_fast(clk_fast)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // bench model
  bit m_run, m_irq, m_mask, m_fmul, m_cfast, m_rom, m_ram, m_load;
  logic [7:0] m_lo, m_hi;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a, input bit rb);
    case (a)
      8'h1E:   return m_lo;
      8'h1F:   return m_hi;
      8'h30:   return {1'b0, rb, m_run, 5'b0};
      8'h31:   return {m_irq, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_outs();
    chk("R2 run_en", {15'd0, run_en}, {15'd0, m_run});
    chk("R2/R7 pc_load", {15'd0, pc_load}, {15'd0, m_load});
    if (m_load) chk("R2 pc_value", pc_value, {m_hi, m_lo});
    chk("R5 host_irq", {15'd0, host_irq}, {15'd0, m_irq & ~m_mask});
    chk("R10 rom_to_core", {15'd0, rom_to_core}, {15'd0, m_rom});
    chk("R10 ram_to_core", {15'd0, ram_to_core}, {15'd0, m_ram});
    chk("R11 clk_fast", {15'd0, clk_fast}, {15'd0, m_cfast});
    chk("R11 fast_mult", {15'd0, fast_mult}, {15'd0, m_fmul & ~m_cfast});
  endtask

  // One bus cycle: drive after the falling edge, model at the rising edge.
  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input logic [7:0] d, input bit st, input bit rb);
    bit pcs, gcl, sev;
    hwr = w; hrd = r; haddr = a; hwdata = d; core_stop = st; rom_busy = rb;
    #2;
    if (r) chk("R9/R3/R6 read", {8'd0, hrdata}, {8'd0, exp_rd(a, rb)});
    @(posedge clk);
    pcs = w && a == 8'h1F;
    gcl = w && a == 8'h30 && !d[5];
    sev = !pcs && m_run && st;
    if (w && a == 8'h1E) m_lo = d;
    if (w && a == 8'h1F) m_hi = d;
    if (w && a == 8'h37) begin m_mask = d[7]; m_fmul = d[5]; end
    if (w && a == 8'h39) m_cfast = d[0];
    if (w && a == 8'h3A) begin m_rom = d[4]; m_ram = d[3]; end
    if (r && a == 8'h31) m_irq = 0;
    if (sev) m_irq = 1;
    if (pcs) m_run = 1;
    else if (m_run && (st || gcl)) m_run = 0;
    m_load = pcs;
    @(negedge clk);
    hwr = 0; hrd = 0; core_stop = 0;
    check_outs();
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    hwr = 0; hrd = 0; haddr = 0; hwdata = 0; core_stop = 0; rom_busy = 0;
    {m_run, m_irq, m_mask, m_fmul, m_cfast, m_rom, m_ram, m_load} = '0;
    m_lo = 0; m_hi = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_outs();
    cyc(0, 1, 8'h31, 0, 0, 0);
    cyc(0, 1, 8'h30, 0, 0, 1);   // R9 busy bit mirrors input

    // R2: low byte alone does not start, high byte does
    cyc(1, 0, 8'h1E, 8'h34, 0, 0);
    cyc(0, 1, 8'h30, 0, 0, 0);
    cyc(1, 0, 8'h1F, 8'h12, 0, 0);
    cyc(0, 1, 8'h30, 0, 0, 1);
    // R4: GO write of 1 has no effect, write of 0 stops without flag
    cyc(1, 0, 8'h30, 8'h20, 0, 0);
    cyc(1, 0, 8'h30, 8'h00, 0, 0);
    cyc(0, 1, 8'h31, 0, 0, 0);
    // R3/R5: core stop raises flag and unmasked line
    cyc(1, 0, 8'h1F, 8'h40, 0, 0);
    cyc(0, 0, 8'h00, 0, 1, 0);
    // R6: read clears
    cyc(0, 1, 8'h31, 0, 0, 0);
    // R5: masked stop, flag set but line low
    cyc(1, 0, 8'h37, 8'h80, 0, 0);
    cyc(1, 0, 8'h1F, 8'h41, 0, 0);
    cyc(0, 0, 8'h00, 0, 1, 0);
    cyc(0, 1, 8'h31, 0, 0, 0);
    cyc(1, 0, 8'h37, 8'h00, 0, 0);
    // R6: read and stop in same cycle -> set wins
    cyc(1, 0, 8'h1F, 8'h42, 0, 0);
    cyc(0, 1, 8'h31, 0, 1, 0);
    cyc(0, 1, 8'h31, 0, 0, 0);
    // R7: restart while running, with simultaneous stop
    cyc(1, 0, 8'h1F, 8'h50, 0, 0);
    cyc(1, 0, 8'h1F, 8'h51, 1, 0);
    cyc(0, 1, 8'h31, 0, 0, 0);
    cyc(1, 0, 8'h30, 8'h00, 0, 0);
    // R8: stop while idle ignored
    cyc(0, 0, 8'h00, 0, 1, 0);
    cyc(0, 1, 8'h31, 0, 0, 0);
    // R10/R11: bus bits and clock constraint
    cyc(1, 0, 8'h3A, 8'h10, 0, 0);
    cyc(1, 0, 8'h3A, 8'h08, 0, 0);
    cyc(1, 0, 8'h37, 8'h20, 0, 0);
    cyc(1, 0, 8'h39, 8'h01, 0, 0);
    cyc(1, 0, 8'h39, 8'h00, 0, 0);

    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, d;
      int unsigned sel;
      sel = $urandom_range(0, 8);
      case (sel)
        0: a = 8'h1E; 1: a = 8'h1F; 2: a = 8'h30; 3: a = 8'h31;
        4: a = 8'h37; 5: a = 8'h39; 6: a = 8'h3A; 7: a = 8'h1F;
        default: a = 8'($urandom);
      endcase
      d = 8'($urandom);
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, a, d,
          $urandom_range(0, 3) == 0, 1'($urandom));
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule